// File: doc/BRIEF.md
# Load Tracking Frequency Request Generator

This block watches how busy a processor is and tells software when the clock should go up or down. At a programmable sampling rate it takes a load sample. The sample is a fixed contribution from the processor busy input plus the programmed weights of whichever of sixteen activity inputs are high. An exponential moving average smooths the samples. The smoothed value is compared with an up threshold, a down threshold and a panic threshold.

A normal increase or decrease is issued only after the crossing has lasted a programmable number of samples. A panic crossing is issued on the first sample. Requests that make no sense at the present operating level are suppressed: at the low level no decrease, and at the turbo level no increase and no panic. The two-bit request code and the interrupt then hold until software pulses the update-done input. Software programs the block through a plain write port. There is no data stream, so no port uses a valid/ready handshake and none exerts back-pressure. Every pin is a plain control or status pin.

Top module: `ltrack_freq_req`

## Requirements
- R1: `req_code` uses 0 for idle, 1 for increase, 2 for decrease and 3 for panic increase. `req_irq` is high exactly when `req_code` is non-zero.
- R2: An increase is issued when the smoothed load has been strictly greater than the up threshold on the required number of consecutive evaluated samples. That number is the up persistence count, where 0 acts as 1.
- R3: A decrease is issued when the smoothed load has been strictly below the down threshold on the required number of consecutive evaluated samples. That number is the down persistence count, where 0 acts as 1.
- R4: A sample whose smoothed load is strictly greater than the panic threshold issues code 3 at once, ignoring persistence. It takes priority over the other two paths. A load equal to the panic threshold is not a panic.
- R5: A sample that lies inside the band between the thresholds (inclusive) clears both persistence counters. Issuing a request also clears both counters.
- R6: The smoothed value starts at zero on enable and follows avg += (load - avg) / 2^shift. It keeps 8 fractional bits, and the integer part is compared. A shift of 0 passes each sample straight through.
- R7: The load sample is the sum of 48 (when `cpu_busy` is high) and the 4-bit weights of the high `gp_act` inputs, saturated at 255. A weight of 0 removes its input.
- R8: One sample is taken every divider+1 clock cycles while enabled.
- R9: At the low level (control bit 2 = 0) no decrease is issued. At the turbo level (bit 2 = 1) neither an increase nor a panic is issued.
- R10: While the mask bit (control bit 1) is set, samples are not evaluated and no new request is issued.
- R11: A request holds its code and interrupt until `upd_done` is high at a clock edge. The code then returns to 0 on that edge, and no sample is evaluated while a request is pending.
- R12: While the enable bit (control bit 0) is clear, the code and interrupt are 0 one cycle later, and the divider, filter and counters are held cleared.
- R13: After reset the outputs are 0 and the block is disabled. The register layout, written when `cfg_we` is high, is as follows:
  - address 0: control (enable bit 0, mask bit 1, level bit 2)
  - address 1: thresholds (up [7:0], down [15:8], panic [23:16])
  - address 2: persistence counts (up [7:0], down [15:8])
  - address 3: pacing (divider [7:0], shift [10:8])
  - addresses 4 and 5: 4-bit weights, with input i at word 4+i/8, bits [4*(i%8)+3 : 4*(i%8)]

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cpu_busy | input | 1 | Processor busy indication |
| gp_act | input | 16 | Weighted activity inputs |
| upd_done | input | 1 | Software update-finish acknowledge |
| req_code | output | 2 | Frequency change request code |
| req_irq | output | 1 | Interrupt toward software |

## Verification
The hardest case to reach is a persistence counter that a single in-band sample clears mid-run. The sampling instants are not visible at the ports, so no test can line a stimulus edge up with a tick. The stimulus slows the divider to eight cycles per sample. It then sets phase lengths so that each phase holds a bounded number of samples whatever the tick phase is. The time to the next request then separates a cleared counter from a kept one. The same bounding-window approach checks the divider rate, the counter clearing on issue and the filter's settling time.

// File: rtl/ltrack_pkg.sv
package ltrack_pkg;
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_UP    = 2'd1,
    REQ_DOWN  = 2'd2,
    REQ_PANIC = 2'd3
  } req_code_e;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_THR  = 1;
  localparam int ADDR_CNT  = 2;
  localparam int ADDR_PACE = 3;
  localparam int ADDR_WGT0 = 4;

  localparam int FLD_STRIDE = 8;

  localparam int RST_UP_THR  = 30;
  localparam int RST_DN_THR  = 18;
  localparam int RST_PAN_THR = 63;
  localparam int RST_COUNT   = 51;
  localparam int RST_DIV     = 3;
  localparam int RST_SHIFT   = 5;
endpackage

// File: rtl/ltrack_sampler.sv
module ltrack_sampler #(
  parameter int NGP         = 16,
  parameter int WW          = 4,
  parameter int LW          = 8,
  parameter int DW          = 8,
  parameter int BUSY_WEIGHT = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [DW-1:0]           div_val,
  input  logic                    busy,
  input  logic [NGP-1:0]          gp,
  input  logic [NGP-1:0][WW-1:0]  wt,
  output logic [LW-1:0]           smp,
  output logic                    smp_vld
);
  localparam int GPW  = WW + $clog2(NGP);
  localparam int SUMW = ((LW > GPW) ? LW : GPW) + 1;
  localparam logic [SUMW-1:0] SAT = SUMW'((1 << LW) - 1);

  logic [DW-1:0]    div_cnt;
  logic             tick;
  logic [SUMW-1:0]  contrib [NGP];
  logic [SUMW-1:0]  sum;
  logic [LW-1:0]    load;

  assign tick = run && (div_cnt == div_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_cnt <= '0;
    else if (!run)      div_cnt <= '0;
    else if (tick)      div_cnt <= '0;
    else                div_cnt <= div_cnt + DW'(1);
  end

  for (genvar i = 0; i < NGP; i++) begin : g_gate
    assign contrib[i] = gp[i] ? SUMW'(wt[i]) : '0;
  end

  always_comb begin
    sum = busy ? SUMW'(BUSY_WEIGHT) : '0;
    for (int i = 0; i < NGP; i++) sum = sum + contrib[i];
    load = (sum > SAT) ? LW'(SAT) : sum[LW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp     <= '0;
      smp_vld <= 1'b0;
    end else if (!run) begin
      smp     <= '0;
      smp_vld <= 1'b0;
    end else begin
      smp_vld <= tick;
      if (tick) smp <= load;
    end
  end
endmodule

// File: rtl/ltrack_ema.sv
module ltrack_ema #(
  parameter int LW = 8,
  parameter int FW = 8,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [LW-1:0] smp,
  input  logic          smp_vld,
  input  logic [KW-1:0] shift,
  output logic [LW-1:0] avg,
  output logic          avg_vld
);
  localparam int AW = LW + FW;

  logic [AW-1:0]        acc;
  logic signed [AW:0]   diff;
  logic signed [AW:0]   step;

  always_comb begin
    diff = $signed({1'b0, smp, {FW{1'b0}}}) - $signed({1'b0, acc});
    step = diff >>> shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      avg_vld <= 1'b0;
    end else if (!run) begin
      acc     <= '0;
      avg_vld <= 1'b0;
    end else begin
      avg_vld <= smp_vld;
      if (smp_vld) acc <= acc + step[AW-1:0];
    end
  end

  assign avg = acc[AW-1:FW];
endmodule

// File: rtl/ltrack_decide.sv
module ltrack_decide
  import ltrack_pkg::*;
#(
  parameter int LW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          mask,
  input  logic          turbo,
  input  logic [LW-1:0] avg,
  input  logic          avg_vld,
  input  logic [LW-1:0] up_thr,
  input  logic [LW-1:0] dn_thr,
  input  logic [LW-1:0] pan_thr,
  input  logic [CW-1:0] up_need,
  input  logic [CW-1:0] dn_need,
  input  logic          ack,
  output logic [1:0]    code,
  output logic          irq
);
  req_code_e     code_q;
  logic [CW-1:0] up_cnt, dn_cnt, up_nx, dn_nx, up_eff, dn_eff;
  logic          above, below, panic, up_hit, dn_hit, pending;

  always_comb begin
    above  = avg > up_thr;
    below  = avg < dn_thr;
    panic  = avg > pan_thr;
    up_nx  = (up_cnt == '1) ? up_cnt : up_cnt + CW'(1);
    dn_nx  = (dn_cnt == '1) ? dn_cnt : dn_cnt + CW'(1);
    up_eff = (up_need == '0) ? CW'(1) : up_need;
    dn_eff = (dn_need == '0) ? CW'(1) : dn_need;
    up_hit = up_nx >= up_eff;
    dn_hit = dn_nx >= dn_eff;
    pending = code_q != REQ_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= REQ_NONE;
      irq    <= 1'b0;
      up_cnt <= '0;
      dn_cnt <= '0;
    end else if (!run) begin
      code_q <= REQ_NONE;
      irq    <= 1'b0;
      up_cnt <= '0;
      dn_cnt <= '0;
    end else if (pending) begin
      if (ack) begin
        code_q <= REQ_NONE;
        irq    <= 1'b0;
      end
    end else if (avg_vld && !mask) begin
      if (panic && !turbo) begin
        code_q <= REQ_PANIC;
        irq    <= 1'b1;
        up_cnt <= '0;
        dn_cnt <= '0;
      end else if (above) begin
        dn_cnt <= '0;
        if (up_hit && !turbo) begin
          code_q <= REQ_UP;
          irq    <= 1'b1;
          up_cnt <= '0;
        end else begin
          up_cnt <= up_nx;
        end
      end else if (below) begin
        up_cnt <= '0;
        if (dn_hit && turbo) begin
          code_q <= REQ_DOWN;
          irq    <= 1'b1;
          dn_cnt <= '0;
        end else begin
          dn_cnt <= dn_nx;
        end
      end else begin
        up_cnt <= '0;
        dn_cnt <= '0;
      end
    end
  end

  assign code = code_q;
endmodule

// File: rtl/ltrack_freq_req.sv
module ltrack_freq_req
  import ltrack_pkg::*;
#(
  parameter int NGP         = 16,
  parameter int WW          = 4,
  parameter int LW          = 8,
  parameter int CW          = 8,
  parameter int DW          = 8,
  parameter int KW          = 3,
  parameter int FW          = 8,
  parameter int AW          = 4,
  parameter int DATA_W      = 32,
  parameter int BUSY_WEIGHT = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cpu_busy,
  input  logic [NGP-1:0]    gp_act,
  input  logic              upd_done,
  output logic [1:0]        req_code,
  output logic              req_irq
);
  localparam int WPW = DATA_W / WW;
  localparam int NWW = (NGP + WPW - 1) / WPW;

  logic                   ctrl_en, ctrl_mask, ctrl_lvl;
  logic [LW-1:0]          up_thr, dn_thr, pan_thr;
  logic [CW-1:0]          up_need, dn_need;
  logic [DW-1:0]          div_val;
  logic [KW-1:0]          ema_shift;
  logic [NGP-1:0][WW-1:0] gp_wt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_mask <= 1'b0;
      ctrl_lvl  <= 1'b0;
      up_thr    <= LW'(RST_UP_THR);
      dn_thr    <= LW'(RST_DN_THR);
      pan_thr   <= LW'(RST_PAN_THR);
      up_need   <= CW'(RST_COUNT);
      dn_need   <= CW'(RST_COUNT);
      div_val   <= DW'(RST_DIV);
      ema_shift <= KW'(RST_SHIFT);
      gp_wt     <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(ADDR_CTRL): begin
          ctrl_en   <= cfg_wdata[0];
          ctrl_mask <= cfg_wdata[1];
          ctrl_lvl  <= cfg_wdata[2];
        end
        AW'(ADDR_THR): begin
          up_thr  <= cfg_wdata[0 +: LW];
          dn_thr  <= cfg_wdata[FLD_STRIDE +: LW];
          pan_thr <= cfg_wdata[2*FLD_STRIDE +: LW];
        end
        AW'(ADDR_CNT): begin
          up_need <= cfg_wdata[0 +: CW];
          dn_need <= cfg_wdata[FLD_STRIDE +: CW];
        end
        AW'(ADDR_PACE): begin
          div_val   <= cfg_wdata[0 +: DW];
          ema_shift <= cfg_wdata[FLD_STRIDE +: KW];
        end
        default: ;
      endcase
      for (int w = 0; w < NWW; w++) begin
        if (cfg_addr == AW'(ADDR_WGT0 + w)) begin
          for (int j = 0; j < WPW; j++) begin
            if (w * WPW + j < NGP) gp_wt[w*WPW+j] <= cfg_wdata[j*WW +: WW];
          end
        end
      end
    end
  end

  logic [LW-1:0] smp, avg;
  logic          smp_vld, avg_vld;

  ltrack_sampler #(
    .NGP(NGP), .WW(WW), .LW(LW), .DW(DW), .BUSY_WEIGHT(BUSY_WEIGHT)
  ) u_sampler (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .div_val(div_val),
    .busy(cpu_busy), .gp(gp_act), .wt(gp_wt), .smp(smp), .smp_vld(smp_vld)
  );

  ltrack_ema #(.LW(LW), .FW(FW), .KW(KW)) u_ema (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .smp(smp), .smp_vld(smp_vld),
    .shift(ema_shift), .avg(avg), .avg_vld(avg_vld)
  );

  ltrack_decide #(.LW(LW), .CW(CW)) u_decide (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .mask(ctrl_mask), .turbo(ctrl_lvl),
    .avg(avg), .avg_vld(avg_vld), .up_thr(up_thr), .dn_thr(dn_thr),
    .pan_thr(pan_thr), .up_need(up_need), .dn_need(dn_need),
    .ack(upd_done), .code(req_code), .irq(req_irq)
  );
endmodule

// File: rtl/ltrack_checker.sv
module ltrack_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_code,
  input logic       req_irq,
  input logic       upd_done,
  input logic       ctrl_en,
  input logic       ctrl_mask,
  input logic       ctrl_lvl
);
  p_irq_tracks_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_irq == (req_code != 2'd0));

  p_hold_until_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code != 2'd0 && !upd_done && ctrl_en) |=> $stable(req_code));

  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_code != 2'd0 && upd_done && ctrl_en) |=> (req_code == 2'd0));

  p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (req_code == 2'd0 && !req_irq));

  p_no_up_at_turbo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_code) == 2'd0 && (req_code == 2'd1 || req_code == 2'd3))
      |-> !$past(ctrl_lvl));

  p_no_down_at_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_code) == 2'd0 && req_code == 2'd2) |-> $past(ctrl_lvl));

  p_mask_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_code) == 2'd0 && req_code != 2'd0) |-> !$past(ctrl_mask));
endmodule

bind ltrack_freq_req ltrack_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_code(req_code), .req_irq(req_irq),
  .upd_done(upd_done), .ctrl_en(ctrl_en), .ctrl_mask(ctrl_mask),
  .ctrl_lvl(ctrl_lvl)
);

// File: tb/test_ltrack_freq_req.sv
module test_ltrack_freq_req;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cpu_busy = 1'b0;
  logic [15:0] gp_act = '0;
  logic        upd_done = 1'b0;
  logic [1:0]  req_code;
  logic        req_irq;

  int n_tests = 0;
  int n_fail  = 0;

  ltrack_freq_req i_ltrack_freq_req (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cpu_busy(cpu_busy), .gp_act(gp_act),
    .upd_done(upd_done), .req_code(req_code), .req_irq(req_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        busy;
    logic [15:0] gp;
    logic        turbo;
    logic [1:0]  exp;
  } vec_t;

  // weights: gp0=9, gp1..7=i+1, gp8..15=i-7; thresholds up 40, dn 10, panic 120
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 16'h0000, 1'b0, 2'd1},  // R2 load 48
    '{1'b0, 16'h0000, 1'b0, 2'd0},  // R9 decrease blocked at low
    '{1'b0, 16'h0000, 1'b1, 2'd2},  // R3 load 0 at turbo
    '{1'b1, 16'h0000, 1'b1, 2'd0},  // R9 increase blocked at turbo
    '{1'b1, 16'hECFF, 1'b0, 2'd1},  // R4 load 120 equals panic
    '{1'b1, 16'hFFFF, 1'b0, 2'd3},  // R4 load 128 panic
    '{1'b1, 16'hFFFF, 1'b1, 2'd0},  // R9 panic blocked at turbo
    '{1'b0, 16'h0101, 1'b1, 2'd0},  // R3 load 10 equals down
    '{1'b0, 16'h10FE, 1'b0, 2'd0},  // R2 load 40 equals up
    '{1'b0, 16'h11FE, 1'b0, 2'd1},  // R2 load 41
    '{1'b0, 16'h0001, 1'b1, 2'd2}   // R3 load 9
  };

  task automatic check_eq(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_rng(input string tag, input int act, input int lo, input int hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ctrl(input logic lvl, input logic msk, input logic en);
    wr(4'd0, {29'd0, lvl, msk, en});
  endtask

  task automatic ack();
    upd_done = 1'b1;
    @(negedge clk);
    upd_done = 1'b0;
  endtask

  task automatic measure(input int maxc, output int t);
    t = -1;
    for (int c = 1; c <= maxc; c++) begin
      @(negedge clk);
      if (req_code != 2'd0) begin
        t = c;
        break;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL R13 watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R13 reset code", req_code, 0);
    check_eq("R13 reset irq", req_irq, 0);

    wr(4'd1, (32'd120 << 16) | (32'd10 << 8) | 32'd40);
    wr(4'd2, (32'd2 << 8) | 32'd2);
    wr(4'd3, 32'd1);
    wr(4'd4, 32'h87654329);
    wr(4'd5, 32'h87654321);

    for (int v = 0; v < NVEC; v++) begin
      ctrl(VECS[v].turbo, 1'b0, 1'b0);
      cpu_busy = VECS[v].busy;
      gp_act   = VECS[v].gp;
      ctrl(VECS[v].turbo, 1'b0, 1'b1);
      repeat (40) @(negedge clk);
      check_eq($sformatf("R1 vector %0d code", v), req_code, VECS[v].exp);
      check_eq($sformatf("R1 vector %0d irq", v), req_irq, (VECS[v].exp != 0) ? 1 : 0);
      if (VECS[v].exp != 0) begin
        ack();
        check_eq($sformatf("R11 vector %0d ack", v), req_code, 0);
      end
    end

    // R8 sample pacing: 3 samples at period 16 then at period 2
    ctrl(1'b0, 1'b0, 1'b0);
    wr(4'd2, (32'd2 << 8) | 32'd3);
    wr(4'd3, 32'd15);
    cpu_busy = 1'b0; gp_act = '0;
    ctrl(1'b0, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    cpu_busy = 1'b1;
    measure(100, t);
    check_rng("R8 divider 15", t, 33, 52);
    ack();
    ctrl(1'b0, 1'b0, 1'b0);
    wr(4'd3, 32'd1);
    cpu_busy = 1'b0;
    ctrl(1'b0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    cpu_busy = 1'b1;
    measure(30, t);
    check_rng("R8 divider 1", t, 5, 10);
    ack();

    // R5 persistence counter cleared by an in-band sample, period 8, need 4
    ctrl(1'b0, 1'b0, 1'b0);
    wr(4'd2, (32'd2 << 8) | 32'd4);
    wr(4'd3, 32'd7);
    cpu_busy = 1'b0; gp_act = 16'h0103;
    ctrl(1'b0, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    cpu_busy = 1'b1; gp_act = '0;
    repeat (20) @(negedge clk);
    check_eq("R2 not yet persistent", req_code, 0);
    cpu_busy = 1'b0; gp_act = 16'h0103;
    repeat (24) @(negedge clk);
    check_eq("R5 band quiet", req_code, 0);
    cpu_busy = 1'b1; gp_act = '0;
    measure(80, t);
    check_rng("R5 cleared in band", t, 25, 40);
    ack();
    measure(80, t);
    check_rng("R5 cleared on issue", t, 20, 40);
    ack();

    // R10 mask, R11 hold, R12 disable
    ctrl(1'b0, 1'b0, 1'b0);
    wr(4'd2, (32'd2 << 8) | 32'd2);
    wr(4'd3, 32'd1);
    cpu_busy = 1'b1; gp_act = '0;
    ctrl(1'b0, 1'b1, 1'b1);
    repeat (40) @(negedge clk);
    check_eq("R10 masked", req_code, 0);
    ctrl(1'b0, 1'b0, 1'b1);
    measure(20, t);
    check_rng("R10 unmasked", t, 1, 10);
    cpu_busy = 1'b0;
    repeat (30) @(negedge clk);
    check_eq("R11 code held", req_code, 1);
    check_eq("R11 irq held", req_irq, 1);
    ack();
    check_eq("R11 ack clears", req_code, 0);
    repeat (30) @(negedge clk);
    check_eq("R9 low blocks decrease", req_code, 0);
    ctrl(1'b1, 1'b0, 1'b1);
    measure(20, t);
    check_eq("R9 turbo allows decrease", req_code, 2);
    ctrl(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check_eq("R12 disable code", req_code, 0);
    check_eq("R12 disable irq", req_irq, 0);

    // R7 zero weights remove inputs
    wr(4'd4, 32'd0);
    wr(4'd5, 32'd0);
    cpu_busy = 1'b0; gp_act = 16'hFFFF;
    ctrl(1'b1, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    check_eq("R7 zero weights", req_code, 2);
    ack();
    ctrl(1'b1, 1'b0, 1'b0);
    wr(4'd4, 32'h0000000F);
    gp_act = 16'h0001;
    ctrl(1'b1, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    check_eq("R7 single weight 15", req_code, 0);

    // R6 smoothing: load 100, up 90, shift 3 then shift 0
    ctrl(1'b0, 1'b0, 1'b0);
    wr(4'd1, (32'd255 << 16) | 32'd90);
    wr(4'd2, (32'd1 << 8) | 32'd1);
    wr(4'd3, (32'd3 << 8) | 32'd1);
    wr(4'd4, 32'h87654329);
    wr(4'd5, 32'h87654321);
    cpu_busy = 1'b1; gp_act = 16'h80FF;
    ctrl(1'b0, 1'b0, 1'b1);
    measure(80, t);
    check_rng("R6 shift 3 settling", t, 30, 50);
    ack();
    ctrl(1'b0, 1'b0, 1'b0);
    wr(4'd3, 32'd1);
    ctrl(1'b0, 1'b0, 1'b1);
    measure(20, t);
    check_rng("R6 shift 0 direct", t, 1, 8);
    ack();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule